// File: doc/BRIEF.md
# Weekly Clock-Calendar Counter

This block keeps time of day and calendar date from a fast reference clock. A prescaler divides the reference clock down to one pulse per second. That pulse advances seconds, minutes and hours. Each midnight carry then advances two things side by side: a day-of-week index and a full date made of day of month, month and a four-digit year. The date side knows how long each month is and applies the Gregorian leap-year rule. After year 9999 the year wraps to 0.

A synchronous load port presets every field at once and restarts the second in progress. Values outside a field's range are clamped. A run enable freezes or releases the count. Every field is presented in binary. A one-cycle strobe marks the second tick and each field rollover, so neighbouring logic can react without comparing field values.

Top module: `clkcal_top`

## Requirements
- R1: While run_i is high and load_i is low, tick_o pulses for one cycle once every TICK_DIV reference cycles (default 10,000,000). While run_i is low, the prescaler and every field hold their values.
- R2: sec_o and min_o count 0..59. A seconds wrap to 0 increments min_o and pulses sec_wrap_o. A minutes wrap to 0 increments hour_o and pulses min_wrap_o.
- R3: hour_o counts 0..23. A wrap to 0 pulses day_wrap_o and advances both wday_o and mday_o in the same cycle.
- R4: wday_o counts 0..6 and wraps to 0 on a midnight carry, pulsing week_wrap_o. It never affects the date fields.
- R5: mday_o starts at 1. Its last value is 31 for months 1, 3, 5, 7, 8, 10 and 12, 30 for months 4, 6, 9 and 11, and 28 for month 2, or 29 in a leap year. Passing the last day sets mday_o to 1, increments month_o and pulses mday_wrap_o.
- R6: A year is leap when it is divisible by 400, or divisible by 4 but not by 100. Year 0 is leap.
- R7: month_o counts 1..12. After 12 it returns to 1, increments year_o and pulses year_wrap_o.
- R8: year_o counts 0..9999. Passing 9999 sets it to 0 and pulses overflow_o for one cycle.
- R9: While load_i is high, every field takes its ld_*_i value on each clock and the prescaler clears. Load has priority over run_i. The first tick after load falls TICK_DIV run cycles after load_i drops.
- R10: Loaded values are clamped. sec and min are limited to 59, hour to 23 and wday to 6. month is held to 1..12 and year to at most 9999. mday is held to 1 up to the last day of the clamped month and year.
- R11: All carries resolve in the tick's clock edge. Every field change and its strobe appear together in the cycle after that edge. Strobes are low after reset and during load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Count enable |
| load_i | input | 1 | Synchronous preset of all fields |
| ld_sec_i | input | 6 | Preset seconds |
| ld_min_i | input | 6 | Preset minutes |
| ld_hour_i | input | 5 | Preset hours |
| ld_wday_i | input | 3 | Preset day of week |
| ld_mday_i | input | 5 | Preset day of month |
| ld_month_i | input | 4 | Preset month |
| ld_year_i | input | 14 | Preset year |
| sec_o | output | 6 | Seconds |
| min_o | output | 6 | Minutes |
| hour_o | output | 5 | Hours |
| wday_o | output | 3 | Day of week |
| mday_o | output | 5 | Day of month |
| month_o | output | 4 | Month |
| year_o | output | 14 | Year |
| tick_o | output | 1 | One-second strobe |
| sec_wrap_o | output | 1 | Seconds rolled over |
| min_wrap_o | output | 1 | Minutes rolled over |
| day_wrap_o | output | 1 | Hours rolled over (midnight) |
| week_wrap_o | output | 1 | Day of week rolled over |
| mday_wrap_o | output | 1 | Day of month rolled over |
| year_wrap_o | output | 1 | Month rolled over into a new year |
| overflow_o | output | 1 | Year wrapped from 9999 to 0 |

## Verification
The assertions assume TICK_DIV is at least 2, so that two ticks can never fall on adjacent cycles. They also rely on the load path clamping every field, so that no range property can see an illegal value coming from the ports. The bench runs with a small TICK_DIV to keep each second short. It deliberately loads out-of-range values, including month 0, day 0 and all-ones patterns, so the clamps are exercised rather than assumed. It places loads just before month ends, leap-year boundaries and year 9999, so that every carry chain fires within a few seconds.

// File: rtl/clkcal_pkg.sv
package clkcal_pkg;
  localparam int SEC_W   = 6;
  localparam int HOUR_W  = 5;
  localparam int WDAY_W  = 3;
  localparam int MDAY_W  = 5;
  localparam int MONTH_W = 4;
  localparam int YEAR_W  = 14;

  localparam logic [SEC_W-1:0]   SEC_MAX   = 6'd59;
  localparam logic [HOUR_W-1:0]  HOUR_MAX  = 5'd23;
  localparam logic [WDAY_W-1:0]  WDAY_MAX  = 3'd6;
  localparam logic [MONTH_W-1:0] MONTH_MAX = 4'd12;
  localparam logic [YEAR_W-1:0]  YEAR_MAX  = 14'd9999;

  function automatic logic is_leap(input logic [YEAR_W-1:0] y);
    logic by4, by100, by400;
    by4   = (y % 14'd4) == 14'd0;
    by100 = (y % 14'd100) == 14'd0;
    by400 = (y % 14'd400) == 14'd0;
    return by400 || (by4 && !by100);
  endfunction

  function automatic logic [MDAY_W-1:0] last_day(input logic [MONTH_W-1:0] m,
                                                 input logic [YEAR_W-1:0] y);
    logic [MDAY_W-1:0] d;
    unique case (m)
      4'd4, 4'd6, 4'd9, 4'd11: d = 5'd30;
      4'd2:                    d = is_leap(y) ? 5'd29 : 5'd28;
      default:                 d = 5'd31;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/clkcal_prescaler.sv
module clkcal_prescaler #(
  parameter int TICK_DIV = 10_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic load_i,
  output logic tick_o,    // combinational, drives field advance
  output logic tick_q_o   // registered, aligned with field update
);
  localparam int CNT_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             tick_q;

  assign tick_o   = run_i && !load_i && (cnt_q == CNT_LAST);
  assign tick_q_o = tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= tick_o;
      if (load_i)      cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else if (run_i)  cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_cnt_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LAST);
  assert_tick_gap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |=> !tick_q);
  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/clkcal_time.sv
module clkcal_time
  import clkcal_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [SEC_W-1:0]  ld_sec_i,
  input  logic [SEC_W-1:0]  ld_min_i,
  input  logic [HOUR_W-1:0] ld_hour_i,
  input  logic [WDAY_W-1:0] ld_wday_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [SEC_W-1:0]  min_o,
  output logic [HOUR_W-1:0] hour_o,
  output logic [WDAY_W-1:0] wday_o,
  output logic              day_carry_o,
  output logic              sec_wrap_o,
  output logic              min_wrap_o,
  output logic              day_wrap_o,
  output logic              week_wrap_o
);
  logic [SEC_W-1:0]  sec_q, min_q;
  logic [HOUR_W-1:0] hour_q;
  logic [WDAY_W-1:0] wday_q;
  logic sec_end, min_end, hour_end;
  logic sw_q, mw_q, dw_q, ww_q;

  assign sec_end     = tick_i && (sec_q == SEC_MAX);
  assign min_end     = sec_end && (min_q == SEC_MAX);
  assign hour_end    = min_end && (hour_q == HOUR_MAX);
  assign day_carry_o = hour_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0; min_q <= '0; hour_q <= '0; wday_q <= '0;
      sw_q <= 1'b0; mw_q <= 1'b0; dw_q <= 1'b0; ww_q <= 1'b0;
    end else begin
      sw_q <= 1'b0; mw_q <= 1'b0; dw_q <= 1'b0; ww_q <= 1'b0;
      if (load_i) begin
        sec_q  <= (ld_sec_i  > SEC_MAX)  ? SEC_MAX  : ld_sec_i;
        min_q  <= (ld_min_i  > SEC_MAX)  ? SEC_MAX  : ld_min_i;
        hour_q <= (ld_hour_i > HOUR_MAX) ? HOUR_MAX : ld_hour_i;
        wday_q <= (ld_wday_i > WDAY_MAX) ? WDAY_MAX : ld_wday_i;
      end else if (tick_i) begin
        sec_q <= sec_end ? '0 : sec_q + 1'b1;
        sw_q  <= sec_end;
        if (sec_end) begin
          min_q <= min_end ? '0 : min_q + 1'b1;
          mw_q  <= min_end;
        end
        if (min_end) begin
          hour_q <= hour_end ? '0 : hour_q + 1'b1;
          dw_q   <= hour_end;
        end
        if (hour_end) begin
          wday_q <= (wday_q == WDAY_MAX) ? '0 : wday_q + 1'b1;
          ww_q   <= (wday_q == WDAY_MAX);
        end
      end
    end
  end

  assign sec_o = sec_q; assign min_o = min_q; assign hour_o = hour_q; assign wday_o = wday_q;
  assign sec_wrap_o = sw_q; assign min_wrap_o = mw_q;
  assign day_wrap_o = dw_q; assign week_wrap_o = ww_q;

  assert_sec_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_q <= SEC_MAX && min_q <= SEC_MAX);
  assert_sec_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_q |-> sec_q == '0);
  assert_hour_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hour_q <= HOUR_MAX);
  assert_midnight_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dw_q |-> (hour_q == '0 && min_q == '0 && sec_q == '0));
  assert_wday_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wday_q <= WDAY_MAX);
  assert_wday_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !hour_end) |=> $stable(wday_q));
endmodule

// File: rtl/clkcal_date.sv
module clkcal_date
  import clkcal_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               day_i,
  input  logic               load_i,
  input  logic [MDAY_W-1:0]  ld_mday_i,
  input  logic [MONTH_W-1:0] ld_month_i,
  input  logic [YEAR_W-1:0]  ld_year_i,
  output logic [MDAY_W-1:0]  mday_o,
  output logic [MONTH_W-1:0] month_o,
  output logic [YEAR_W-1:0]  year_o,
  output logic               mday_wrap_o,
  output logic               year_wrap_o,
  output logic               overflow_o
);
  logic [MDAY_W-1:0]  mday_q, ld_last, ld_mday_c;
  logic [MONTH_W-1:0] month_q, ld_month_c;
  logic [YEAR_W-1:0]  year_q, ld_year_c;
  logic mday_end, month_end, year_end;
  logic dw_q, yw_q, ov_q;

  always_comb begin
    ld_year_c  = (ld_year_i > YEAR_MAX) ? YEAR_MAX : ld_year_i;
    if (ld_month_i == '0)            ld_month_c = 4'd1;
    else if (ld_month_i > MONTH_MAX) ld_month_c = MONTH_MAX;
    else                             ld_month_c = ld_month_i;
    ld_last = last_day(ld_month_c, ld_year_c);
    if (ld_mday_i == '0)           ld_mday_c = 5'd1;
    else if (ld_mday_i > ld_last)  ld_mday_c = ld_last;
    else                           ld_mday_c = ld_mday_i;
  end

  assign mday_end  = day_i && (mday_q == last_day(month_q, year_q));
  assign month_end = mday_end && (month_q == MONTH_MAX);
  assign year_end  = month_end && (year_q == YEAR_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mday_q <= 5'd1; month_q <= 4'd1; year_q <= '0;
      dw_q <= 1'b0; yw_q <= 1'b0; ov_q <= 1'b0;
    end else begin
      dw_q <= 1'b0; yw_q <= 1'b0; ov_q <= 1'b0;
      if (load_i) begin
        mday_q  <= ld_mday_c;
        month_q <= ld_month_c;
        year_q  <= ld_year_c;
      end else if (day_i) begin
        mday_q <= mday_end ? 5'd1 : mday_q + 1'b1;
        dw_q   <= mday_end;
        if (mday_end) begin
          month_q <= month_end ? 4'd1 : month_q + 1'b1;
          yw_q    <= month_end;
        end
        if (month_end) begin
          year_q <= year_end ? '0 : year_q + 1'b1;
          ov_q   <= year_end;
        end
      end
    end
  end

  assign mday_o = mday_q; assign month_o = month_q; assign year_o = year_q;
  assign mday_wrap_o = dw_q; assign year_wrap_o = yw_q; assign overflow_o = ov_q;

  assert_mday_limit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mday_q >= 5'd1 && mday_q <= last_day(month_q, year_q));
  assert_month_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    month_q >= 4'd1 && month_q <= MONTH_MAX);
  assert_year_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    yw_q |-> (month_q == 4'd1 && mday_q == 5'd1));
  assert_year_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    year_q <= YEAR_MAX);
  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ov_q |-> (year_q == '0 && yw_q));
  assert_ovf_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ov_q |=> !ov_q);
endmodule

// File: rtl/clkcal_top.sv
module clkcal_top
  import clkcal_pkg::*;
#(
  parameter int TICK_DIV = 10_000_000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               load_i,
  input  logic [SEC_W-1:0]   ld_sec_i,
  input  logic [SEC_W-1:0]   ld_min_i,
  input  logic [HOUR_W-1:0]  ld_hour_i,
  input  logic [WDAY_W-1:0]  ld_wday_i,
  input  logic [MDAY_W-1:0]  ld_mday_i,
  input  logic [MONTH_W-1:0] ld_month_i,
  input  logic [YEAR_W-1:0]  ld_year_i,
  output logic [SEC_W-1:0]   sec_o,
  output logic [SEC_W-1:0]   min_o,
  output logic [HOUR_W-1:0]  hour_o,
  output logic [WDAY_W-1:0]  wday_o,
  output logic [MDAY_W-1:0]  mday_o,
  output logic [MONTH_W-1:0] month_o,
  output logic [YEAR_W-1:0]  year_o,
  output logic               tick_o,
  output logic               sec_wrap_o,
  output logic               min_wrap_o,
  output logic               day_wrap_o,
  output logic               week_wrap_o,
  output logic               mday_wrap_o,
  output logic               year_wrap_o,
  output logic               overflow_o
);
  logic tick, day_carry;

  clkcal_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
    .clk_i, .rst_ni, .run_i, .load_i, .tick_o(tick), .tick_q_o(tick_o)
  );

  clkcal_time u_time (
    .clk_i, .rst_ni, .tick_i(tick), .load_i,
    .ld_sec_i, .ld_min_i, .ld_hour_i, .ld_wday_i,
    .sec_o, .min_o, .hour_o, .wday_o,
    .day_carry_o(day_carry), .sec_wrap_o, .min_wrap_o, .day_wrap_o, .week_wrap_o
  );

  clkcal_date u_date (
    .clk_i, .rst_ni, .day_i(day_carry), .load_i,
    .ld_mday_i, .ld_month_i, .ld_year_i,
    .mday_o, .month_o, .year_o, .mday_wrap_o, .year_wrap_o, .overflow_o
  );

  assert_load_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !(tick_o || sec_wrap_o || day_wrap_o || mday_wrap_o || overflow_o));
endmodule

// File: tb/clkcal_top_tb.sv
module clkcal_top_tb_top;
  localparam int DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, load = 1'b0;
  logic [5:0] ld_sec = '0, ld_min = '0;
  logic [4:0] ld_hour = '0, ld_mday = '0;
  logic [2:0] ld_wday = '0;
  logic [3:0] ld_month = '0;
  logic [13:0] ld_year = '0;
  logic [5:0] sec_o, min_o;
  logic [4:0] hour_o, mday_o;
  logic [2:0] wday_o;
  logic [3:0] month_o;
  logic [13:0] year_o;
  logic tick_o, sec_wrap_o, min_wrap_o, day_wrap_o, week_wrap_o, mday_wrap_o, year_wrap_o, overflow_o;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  clkcal_top #(.TICK_DIV(DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .load_i(load),
    .ld_sec_i(ld_sec), .ld_min_i(ld_min), .ld_hour_i(ld_hour), .ld_wday_i(ld_wday),
    .ld_mday_i(ld_mday), .ld_month_i(ld_month), .ld_year_i(ld_year),
    .sec_o, .min_o, .hour_o, .wday_o, .mday_o, .month_o, .year_o,
    .tick_o, .sec_wrap_o, .min_wrap_o, .day_wrap_o, .week_wrap_o,
    .mday_wrap_o, .year_wrap_o, .overflow_o
  );

  // behavioural reference model
  int m_cnt, m_s, m_mi, m_h, m_w, m_d, m_mo, m_y;
  bit m_tick, m_sw, m_mw, m_dw, m_ww, m_dmw, m_yw, m_ov;

  function automatic bit leap(int y);
    return (y % 400 == 0) || ((y % 4 == 0) && (y % 100 != 0));
  endfunction
  function automatic int mlen(int mo, int y);
    if (mo == 2) return leap(y) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction
  function automatic int lim(int v, int lo, int hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_s = 0; m_mi = 0; m_h = 0; m_w = 0; m_d = 1; m_mo = 1; m_y = 0;
      {m_tick, m_sw, m_mw, m_dw, m_ww, m_dmw, m_yw, m_ov} = '0;
    end else begin
      {m_tick, m_sw, m_mw, m_dw, m_ww, m_dmw, m_yw, m_ov} = '0;
      if (load) begin
        m_cnt = 0;
        m_s = lim(ld_sec, 0, 59); m_mi = lim(ld_min, 0, 59);
        m_h = lim(ld_hour, 0, 23); m_w = lim(ld_wday, 0, 6);
        m_y = lim(ld_year, 0, 9999); m_mo = lim(ld_month, 1, 12);
        m_d = lim(ld_mday, 1, mlen(m_mo, m_y));
      end else if (run) begin
        if (m_cnt == DIV - 1) begin
          m_cnt = 0; m_tick = 1; m_s++;
          if (m_s == 60) begin m_s = 0; m_sw = 1; m_mi++; end
          if (m_mi == 60) begin m_mi = 0; m_mw = 1; m_h++; end
          if (m_h == 24) begin
            m_h = 0; m_dw = 1; m_w++; m_d++;
            if (m_w == 7) begin m_w = 0; m_ww = 1; end
            if (m_d > mlen(m_mo, m_y)) begin m_d = 1; m_dmw = 1; m_mo++; end
            if (m_mo == 13) begin m_mo = 1; m_yw = 1; m_y++; end
            if (m_y == 10000) begin m_y = 0; m_ov = 1; end
          end
        end else m_cnt++;
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare against model every cycle, away from the active edge
  always @(negedge clk) if (rst_n && !done) begin
    chk("R1", "tick_o", tick_o, m_tick);
    chk("R2", "sec_o", sec_o, m_s);
    chk("R2", "min_o", min_o, m_mi);
    chk("R3", "hour_o", hour_o, m_h);
    chk("R4", "wday_o", wday_o, m_w);
    chk("R5", "mday_o", mday_o, m_d);
    chk("R7", "month_o", month_o, m_mo);
    chk("R8", "year_o", year_o, m_y);
    chk("R11", "strobes",
        {sec_wrap_o, min_wrap_o, day_wrap_o, week_wrap_o, mday_wrap_o, year_wrap_o, overflow_o},
        {m_sw, m_mw, m_dw, m_ww, m_dmw, m_yw, m_ov});
  end

  task automatic preset(int s, int mi, int h, int w, int d, int mo, int y);
    @(negedge clk);
    ld_sec = 6'(s); ld_min = 6'(mi); ld_hour = 5'(h); ld_wday = 3'(w);
    ld_mday = 5'(d); ld_month = 4'(mo); ld_year = 14'(y); load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic secs(int n);
    run = 1'b1;
    repeat (n * DIV) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", "reset date", {mday_o, month_o}, {5'd1, 4'd1});
    chk("R11", "reset time", sec_o + min_o + hour_o + wday_o + year_o, 0);
    rst_n = 1'b1;
    secs(3);
    chk("R1", "sec after 3 s", sec_o, 3);
    // R1: run low freezes
    run = 1'b0;
    repeat (20) @(negedge clk);
    chk("R1", "held sec", sec_o, 3);
    // R3/R4/R5: midnight on Jan 31, weekday 6 wraps
    preset(58, 59, 23, 6, 31, 1, 2023);
    secs(2);
    chk("R4", "wday wrap", wday_o, 0);
    chk("R5", "Jan->Feb", {mday_o, month_o}, {5'd1, 4'd2});
    // R6 leap cases
    preset(59, 59, 23, 2, 28, 2, 2023); secs(1);
    chk("R6", "2023 Feb", {mday_o, month_o}, {5'd1, 4'd3});
    preset(59, 59, 23, 2, 28, 2, 2024); secs(1);
    chk("R6", "2024 Feb", mday_o, 29);
    preset(59, 59, 23, 2, 28, 2, 2100); secs(1);
    chk("R6", "2100 Feb", month_o, 3);
    preset(59, 59, 23, 2, 28, 2, 2000); secs(1);
    chk("R6", "2000 Feb", mday_o, 29);
    preset(59, 59, 23, 2, 28, 2, 0); secs(1);
    chk("R6", "year 0 Feb", mday_o, 29);
    preset(59, 59, 23, 2, 29, 2, 2024); secs(1);
    chk("R5", "Feb 29 end", {mday_o, month_o}, {5'd1, 4'd3});
    preset(59, 59, 23, 3, 30, 4, 2024); secs(1);
    chk("R5", "Apr 30 end", {mday_o, month_o}, {5'd1, 4'd5});
    // R7/R8: year end and overflow
    preset(59, 59, 23, 1, 31, 12, 2024); secs(1);
    chk("R7", "new year", year_o, 2025);
    preset(58, 59, 23, 1, 31, 12, 9999); secs(2);
    chk("R8", "overflow year", year_o, 0);
    // R10: clamping
    preset(63, 63, 31, 7, 31, 15, 16383);
    chk("R10", "clamp time", {sec_o, min_o, hour_o, wday_o}, {6'd59, 6'd59, 5'd23, 3'd6});
    chk("R10", "clamp date", year_o, 9999);
    preset(0, 0, 0, 0, 0, 0, 5);
    chk("R10", "clamp zero", {mday_o, month_o}, {5'd1, 4'd1});
    preset(0, 0, 0, 0, 31, 2, 2023);
    chk("R10", "clamp Feb", mday_o, 28);
    // R9: load mid-second restarts prescaler, and overrides run
    secs(1);
    repeat (2) @(negedge clk);
    preset(10, 0, 0, 0, 1, 1, 1);
    chk("R9", "loaded sec", sec_o, 10);
    repeat (DIV - 1) @(negedge clk);
    chk("R9", "no early tick", sec_o, 10);
    @(negedge clk);
    chk("R9", "tick after DIV", sec_o, 11);
    secs(70);
    finish_run();
  end
endmodule